// File: doc/BRIEF.md
# Message-Signalled Interrupt Capability Register File

This block holds the configuration-space structure that a PCI function exposes for message-signalled interrupts. A configuration decoder hands it reads and writes as a byte offset from the start of the capability plus an access width of one, two or four bytes. It answers each read one cycle later with low-justified data. It keeps the control word, the message address, the message data and the per-vector mask bits. Downstream interrupt logic uses the enable bit, the number of enabled vectors, the full address, the data and the mask. Interrupt logic also returns one pending flag per vector, which software can read back through a read-only window.

Two capability options come from the parameterised reset value of the control word: a 64-bit message address and per-vector masking. Together they decide which registers exist and where they sit. Wide addressing moves the data and mask registers up by four bytes. Without per-vector masking there is no mask and no pending window, and the structure is shorter. Writes to the read-only parts of the control word are dropped. Offsets that map to nothing read as zero and ignore writes.

Top module: `msi_cap_regs`

## Requirements
- R1: A word read at offset 0 returns the capability ID 0x05 in bits 7:0, the next-capability pointer in bits 15:8 and the control word in bits 31:16. Byte reads at offsets 0 and 1 return the ID and the pointer, and a halfword read at offset 0 returns both.
- R2: Control-word bit positions are: bit 0 enable, bits 3:1 log2 of vectors supported, bits 6:4 log2 of vectors enabled, bit 7 wide-address capable, bit 8 per-vector-mask capable, bits 15:9 reserved. Only bit 0 and bits 6:4 change on a write: a halfword write at offset 2, or the upper half of a word write at offset 0. All other bits keep their parameter value.
- R3: After reset the enable bit is 0 even if the parameter sets it. Address, data and mask are 0, and the other control bits equal the parameter.
- R4: `msi_vec_count_o` is 2 to the power of control bits 6:4, and is 0 when that field is above 5.
- R5: A word write at offset 4 stores the low address with bits 1:0 cleared.
- R6: With wide addressing, the upper address is a word at 0x8 and data is at 0xC. Without it, data is at 0x8 and no upper address exists. Data takes halfword or word accesses, and a word write keeps its low 16 bits.
- R7: `cap_len_o` equals 0x0A, plus 0x04 with wide addressing, plus 0x0A with per-vector masking.
- R8: With per-vector masking, the pending window starts 4 bytes above the mask. A pending bit reads 1 only when the capability is enabled, the vector's mask bit is 1 and its pending input is high. Without per-vector masking, no pending window exists.
- R9: The mask register sits at 0xC (narrow) or 0x10 (wide). It takes byte writes at any of its four offsets, halfword writes at its base and base+2, and word writes at its base. Only the addressed bytes change, and matching reads return the addressed bytes.
- R10: `msi_mask_o` reads 0 when per-vector masking is absent.
- R11: Reads at unmapped offsets return 0, and writes there change no register. A byte read or write at offset 2 counts as unmapped.
- R12: `cfg_rvalid` is high exactly one cycle after a cycle with `cfg_rd_en`, and `cfg_rdata` then holds the state seen at the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rd_en | input | 1 | Read request |
| cfg_wr_en | input | 1 | Write request |
| cfg_offset | input | 8 | Byte offset within the capability |
| cfg_size | input | 2 | Access width: 0 byte, 1 halfword, 2 word |
| cfg_wdata | input | 32 | Low-justified write value |
| cfg_rdata | output | 32 | Low-justified read value |
| cfg_rvalid | output | 1 | Read value valid |
| vec_pending_i | input | NUM_VEC | Per-vector pending flags |
| msi_enable_o | output | 1 | Capability enable bit |
| msi_vec_count_o | output | 6 | Decoded number of enabled vectors |
| msi_addr_o | output | 64 | Message address, upper half then lower half |
| msi_data_o | output | 16 | Message data |
| msi_mask_o | output | 32 | Per-vector mask bits |
| cap_len_o | output | 8 | Structure length in bytes |

## Verification
The bench runs one instance with wide addressing and masking, and a second instance with neither. This catches a design that hard-codes one layout: such a design would put data or mask at the wrong offset in one of the two instances. It writes every byte of the control word, including offset-2 byte writes and writes to read-only bits. A design that lets those through would show changed capability bits or a changed vector count. It drives enabled-count fields of 6 and 7 to catch a decoder that returns 64 or 128 instead of zero. Pending reads are checked with partly masked vectors, with the capability disabled and with masking absent. These cases expose a window that shows raw pending flags or ignores the enable bit.

// File: rtl/msi_cap_pkg.sv
`timescale 1ns/1ps
package msi_cap_pkg;

    localparam logic [7:0]  CAP_ID_MSI   = 8'h05;
    localparam int          CTL_EN_BIT   = 0;
    localparam int          CTL_64_BIT   = 7;
    localparam int          CTL_PVM_BIT  = 8;
    localparam logic [15:0] CTL_WR_MASK  = 16'h0071;

    typedef enum logic [1:0] {
        ACC_BYTE = 2'd0,
        ACC_HALF = 2'd1,
        ACC_WORD = 2'd2,
        ACC_NONE = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic [15:0] ctrl;
        logic [31:0] addr_lo;
        logic [31:0] addr_hi;
        logic [15:0] data;
        logic [31:0] mask;
    } msi_regs_t;

    typedef struct packed {
        logic       hi_vld;
        logic [7:0] hi_off;
        logic [7:0] data_off;
        logic       mask_vld;
        logic [7:0] mask_off;
        logic [7:0] pend_off;
        logic [7:0] cap_len;
    } msi_layout_t;

    typedef struct packed {
        logic        ctrl_we;
        logic [15:0] ctrl_val;
        logic        lo_we;
        logic        hi_we;
        logic        data_we;
        logic [3:0]  mask_be;
        logic [31:0] mask_val;
    } msi_wr_t;

    function automatic logic [5:0] log2_count(input logic [2:0] field);
        if (field > 3'd5) begin
            return 6'd0;
        end
        return 6'd1 << field;
    endfunction

endpackage

// File: rtl/msi_cap_layout.sv
`timescale 1ns/1ps
module msi_cap_layout
    import msi_cap_pkg::*;
#(
    parameter bit HAS_64  = 1'b1,
    parameter bit HAS_PVM = 1'b1
) (
    output msi_layout_t layout
);
    localparam logic [7:0] LEN_64  = HAS_64  ? 8'h04 : 8'h00;
    localparam logic [7:0] LEN_PVM = HAS_PVM ? 8'h0A : 8'h00;
    localparam logic [7:0] LEN     = 8'h0A + LEN_64 + LEN_PVM;

    generate
        if (HAS_64) begin : g_wide
            always_comb begin
                layout          = '0;
                layout.hi_vld   = 1'b1;
                layout.hi_off   = 8'h08;
                layout.data_off = 8'h0C;
                layout.mask_vld = HAS_PVM;
                layout.mask_off = 8'h10;
                layout.pend_off = 8'h14;
                layout.cap_len  = LEN;
            end
        end else begin : g_narrow
            always_comb begin
                layout          = '0;
                layout.hi_vld   = 1'b0;
                layout.hi_off   = 8'h00;
                layout.data_off = 8'h08;
                layout.mask_vld = HAS_PVM;
                layout.mask_off = 8'h0C;
                layout.pend_off = 8'h10;
                layout.cap_len  = LEN;
            end
        end
    endgenerate
endmodule

// File: rtl/msi_cap_wr_decode.sv
`timescale 1ns/1ps
module msi_cap_wr_decode
    import msi_cap_pkg::*;
(
    input  logic        wr_en,
    input  logic [7:0]  offset,
    input  acc_size_e   size,
    input  logic [31:0] wdata,
    input  msi_layout_t layout,
    output msi_wr_t     wr
);
    logic [3:0]  lane_be;
    logic [31:0] lane_val;

    // Per-byte hit logic for the mask register
    generate
        for (genvar k = 0; k < 4; k++) begin : g_lane
            localparam logic [7:0] BYTE_K = 8'(k);
            localparam logic [7:0] HALF_K = 8'(k & 2);
            logic hit_b, hit_h, hit_w;
            assign hit_b = (size == ACC_BYTE) && (offset == layout.mask_off + BYTE_K);
            assign hit_h = (size == ACC_HALF) && (offset == layout.mask_off + HALF_K);
            assign hit_w = (size == ACC_WORD) && (offset == layout.mask_off);
            assign lane_be[k] = wr_en && layout.mask_vld && (hit_b || hit_h || hit_w);
            assign lane_val[8*k +: 8] = hit_w ? wdata[8*k +: 8] :
                                        hit_h ? wdata[8*(k%2) +: 8] :
                                                wdata[7:0];
        end
    endgenerate

    always_comb begin
        wr          = '0;
        wr.mask_be  = lane_be;
        wr.mask_val = lane_val;
        if (wr_en) begin
            case (size)
                ACC_HALF: begin
                    if (offset == 8'h02) begin
                        wr.ctrl_we  = 1'b1;
                        wr.ctrl_val = wdata[15:0];
                    end else if (offset == layout.data_off) begin
                        wr.data_we = 1'b1;
                    end
                end
                ACC_WORD: begin
                    if (offset == 8'h00) begin
                        wr.ctrl_we  = 1'b1;
                        wr.ctrl_val = wdata[31:16];
                    end else if (offset == 8'h04) begin
                        wr.lo_we = 1'b1;
                    end else if (layout.hi_vld && offset == layout.hi_off) begin
                        wr.hi_we = 1'b1;
                    end else if (offset == layout.data_off) begin
                        wr.data_we = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/msi_cap_rd_mux.sv
`timescale 1ns/1ps
module msi_cap_rd_mux
    import msi_cap_pkg::*;
#(
    parameter logic [7:0] NEXT_PTR = 8'h00
) (
    input  logic [7:0]  offset,
    input  acc_size_e   size,
    input  msi_regs_t   regs,
    input  msi_layout_t layout,
    input  logic [31:0] pend_view,
    output logic [31:0] rdata
);
    always_comb begin
        rdata = '0;
        case (size)
            ACC_BYTE: begin
                if (offset == 8'h00) begin
                    rdata[7:0] = CAP_ID_MSI;
                end else if (offset == 8'h01) begin
                    rdata[7:0] = NEXT_PTR;
                end else if (layout.mask_vld) begin
                    for (int k = 0; k < 4; k++) begin
                        if (offset == layout.mask_off + 8'(k)) begin
                            rdata[7:0] = regs.mask[8*k +: 8];
                        end
                        if (offset == layout.pend_off + 8'(k)) begin
                            rdata[7:0] = pend_view[8*k +: 8];
                        end
                    end
                end
            end
            ACC_HALF: begin
                if (offset == 8'h00) begin
                    rdata[15:0] = {NEXT_PTR, CAP_ID_MSI};
                end else if (offset == 8'h02) begin
                    rdata[15:0] = regs.ctrl;
                end else if (offset == layout.data_off) begin
                    rdata[15:0] = regs.data;
                end else if (layout.mask_vld) begin
                    if (offset == layout.mask_off) begin
                        rdata[15:0] = regs.mask[15:0];
                    end else if (offset == layout.mask_off + 8'h02) begin
                        rdata[15:0] = regs.mask[31:16];
                    end else if (offset == layout.pend_off) begin
                        rdata[15:0] = pend_view[15:0];
                    end else if (offset == layout.pend_off + 8'h02) begin
                        rdata[15:0] = pend_view[31:16];
                    end
                end
            end
            ACC_WORD: begin
                if (offset == 8'h00) begin
                    rdata = {regs.ctrl, NEXT_PTR, CAP_ID_MSI};
                end else if (offset == 8'h04) begin
                    rdata = regs.addr_lo;
                end else if (layout.hi_vld && offset == layout.hi_off) begin
                    rdata = regs.addr_hi;
                end else if (offset == layout.data_off) begin
                    rdata = {16'h0000, regs.data};
                end else if (layout.mask_vld && offset == layout.mask_off) begin
                    rdata = regs.mask;
                end else if (layout.mask_vld && offset == layout.pend_off) begin
                    rdata = pend_view;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/msi_cap_regs.sv
`timescale 1ns/1ps
module msi_cap_regs
    import msi_cap_pkg::*;
#(
    parameter logic [15:0] CTRL_INIT = 16'h0187,
    parameter logic [7:0]  NEXT_PTR  = 8'h00,
    parameter int          NUM_VEC   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_rd_en,
    input  logic               cfg_wr_en,
    input  logic [7:0]         cfg_offset,
    input  logic [1:0]         cfg_size,
    input  logic [31:0]        cfg_wdata,
    output logic [31:0]        cfg_rdata,
    output logic               cfg_rvalid,
    input  logic [NUM_VEC-1:0] vec_pending_i,
    output logic               msi_enable_o,
    output logic [5:0]         msi_vec_count_o,
    output logic [63:0]        msi_addr_o,
    output logic [15:0]        msi_data_o,
    output logic [31:0]        msi_mask_o,
    output logic [7:0]         cap_len_o
);
    localparam bit          HAS_64   = CTRL_INIT[CTL_64_BIT];
    localparam bit          HAS_PVM  = CTRL_INIT[CTL_PVM_BIT];
    localparam logic [15:0] CTRL_RST = CTRL_INIT & ~(16'h0001 << CTL_EN_BIT);

    typedef struct packed {
        msi_regs_t   regs;
        logic [31:0] rdata;
        logic        rvalid;
    } top_state_t;

    top_state_t  st_d, st_q;
    msi_layout_t layout;
    msi_wr_t     wr;
    acc_size_e   acc;
    logic [31:0] pend_ext;
    logic [31:0] pend_view;
    logic [31:0] rd_word;

    assign acc = acc_size_e'(cfg_size);

    msi_cap_layout #(
        .HAS_64  (HAS_64),
        .HAS_PVM (HAS_PVM)
    ) u_layout (
        .layout (layout)
    );

    msi_cap_wr_decode u_wr (
        .wr_en  (cfg_wr_en),
        .offset (cfg_offset),
        .size   (acc),
        .wdata  (cfg_wdata),
        .layout (layout),
        .wr     (wr)
    );

    msi_cap_rd_mux #(
        .NEXT_PTR (NEXT_PTR)
    ) u_rd (
        .offset    (cfg_offset),
        .size      (acc),
        .regs      (st_q.regs),
        .layout    (layout),
        .pend_view (pend_view),
        .rdata     (rd_word)
    );

    // Pending window: masked-and-pending vectors, only while enabled
    always_comb begin
        pend_ext = '0;
        pend_ext[NUM_VEC-1:0] = vec_pending_i;
        if (HAS_PVM && st_q.regs.ctrl[CTL_EN_BIT]) begin
            pend_view = st_q.regs.mask & pend_ext;
        end else begin
            pend_view = '0;
        end
    end

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = cfg_rd_en;
        if (cfg_rd_en) begin
            st_d.rdata = rd_word;
        end
        if (wr.ctrl_we) begin
            st_d.regs.ctrl = (st_q.regs.ctrl & ~CTL_WR_MASK) | (wr.ctrl_val & CTL_WR_MASK);
        end
        if (wr.lo_we) begin
            st_d.regs.addr_lo = {cfg_wdata[31:2], 2'b00};
        end
        if (wr.hi_we) begin
            st_d.regs.addr_hi = cfg_wdata;
        end
        if (wr.data_we) begin
            st_d.regs.data = cfg_wdata[15:0];
        end
        for (int k = 0; k < 4; k++) begin
            if (wr.mask_be[k]) begin
                st_d.regs.mask[8*k +: 8] = wr.mask_val[8*k +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.regs.ctrl <= CTRL_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_rdata       = st_q.rdata;
    assign cfg_rvalid      = st_q.rvalid;
    assign msi_enable_o    = st_q.regs.ctrl[CTL_EN_BIT];
    assign msi_vec_count_o = log2_count(st_q.regs.ctrl[6:4]);
    assign msi_addr_o      = {st_q.regs.addr_hi, st_q.regs.addr_lo};
    assign msi_data_o      = st_q.regs.data;
    assign msi_mask_o      = HAS_PVM ? st_q.regs.mask : 32'h0;
    assign cap_len_o       = layout.cap_len;
endmodule

// File: rtl/msi_cap_regs_chk.sv
`timescale 1ns/1ps
module msi_cap_regs_chk #(
    parameter logic [15:0] CTRL_INIT = 16'h0187
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_rd_en,
    input logic        cfg_wr_en,
    input logic [7:0]  cfg_offset,
    input logic [31:0] cfg_rdata,
    input logic        cfg_rvalid,
    input logic        msi_enable_o,
    input logic [5:0]  msi_vec_count_o,
    input logic [63:0] msi_addr_o
);
    localparam bit         C_PVM    = CTRL_INIT[8];
    localparam logic [7:0] PEND_OFF = CTRL_INIT[7] ? 8'h14 : 8'h10;

    // R2: control state moves only after a write
    assert_ctrl_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr_en |=> ($stable(msi_vec_count_o) && $stable(msi_enable_o)));

    // R4: decoded count is zero or a power of two no larger than 32
    assert_count_pow2_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(msi_vec_count_o) <= 1) && (msi_vec_count_o <= 6'd32));

    // R5: the stored low address is always dword aligned
    assert_addr_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
        msi_addr_o[1:0] == 2'b00);

    // R8: pending window reads zero while disabled
    assert_pend_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (C_PVM && cfg_rd_en && !msi_enable_o && cfg_offset == PEND_OFF) |=> (cfg_rdata == 32'h0));

    // R12: read response one cycle after each request, and only then
    assert_rd_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd_en |=> cfg_rvalid);
    assert_no_spurious_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rd_en |=> !cfg_rvalid);
endmodule

bind msi_cap_regs msi_cap_regs_chk #(.CTRL_INIT(CTRL_INIT)) u_chk (.*);

// File: tb/tb_msi_cap_regs.sv
`timescale 1ns/1ps
module tb_msi_cap_regs;
    localparam time CLK_P = 4ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_P/2) clk = ~clk;

    logic [7:0]  offset = '0;
    logic [1:0]  size = '0;
    logic [31:0] wdata = '0;
    logic rd_a = 0, wr_a = 0, rd_b = 0, wr_b = 0;
    logic [31:0] rdata_a, rdata_b;
    logic        rv_a, rv_b;
    logic [7:0]  pend_a = '0;
    logic [31:0] pend_b = '0;
    logic        en_a, en_b;
    logic [5:0]  cnt_a, cnt_b;
    logic [63:0] addr_a, addr_b;
    logic [15:0] data_a, data_b;
    logic [31:0] mask_a, mask_b;
    logic [7:0]  len_a, len_b;

    int checks = 0;
    int errors = 0;

    bit          q_sel[$];
    logic [31:0] q_exp[$];
    string       q_tag[$];

    msi_cap_regs #(.CTRL_INIT(16'h0187), .NEXT_PTR(8'hA5), .NUM_VEC(8)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_rd_en(rd_a), .cfg_wr_en(wr_a),
        .cfg_offset(offset), .cfg_size(size), .cfg_wdata(wdata),
        .cfg_rdata(rdata_a), .cfg_rvalid(rv_a), .vec_pending_i(pend_a),
        .msi_enable_o(en_a), .msi_vec_count_o(cnt_a), .msi_addr_o(addr_a),
        .msi_data_o(data_a), .msi_mask_o(mask_a), .cap_len_o(len_a));

    msi_cap_regs #(.CTRL_INIT(16'h006A), .NEXT_PTR(8'h40), .NUM_VEC(32)) dut_b (
        .clk(clk), .rst_n(rst_n), .cfg_rd_en(rd_b), .cfg_wr_en(wr_b),
        .cfg_offset(offset), .cfg_size(size), .cfg_wdata(wdata),
        .cfg_rdata(rdata_b), .cfg_rvalid(rv_b), .vec_pending_i(pend_b),
        .msi_enable_o(en_b), .msi_vec_count_o(cnt_b), .msi_addr_o(addr_b),
        .msi_data_o(data_b), .msi_mask_o(mask_b), .cap_len_o(len_b));

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Driver: issue a read and push its expected value to the scoreboard
    task automatic rd(bit sel, logic [7:0] off, logic [1:0] sz, logic [31:0] exp, string tag);
        @(negedge clk);
        offset = off; size = sz;
        if (sel) rd_b = 1'b1; else rd_a = 1'b1;
        q_sel.push_back(sel); q_exp.push_back(exp); q_tag.push_back(tag);
        @(negedge clk);
        rd_a = 1'b0; rd_b = 1'b0;
    endtask

    task automatic wr(bit sel, logic [7:0] off, logic [1:0] sz, logic [31:0] val);
        @(negedge clk);
        offset = off; size = sz; wdata = val;
        if (sel) wr_b = 1'b1; else wr_a = 1'b1;
        @(negedge clk);
        wr_a = 1'b0; wr_b = 1'b0;
    endtask

    // Monitor: pop and compare each read response
    always @(negedge clk) begin : monitor
        bit          s;
        logic [31:0] e;
        string       t;
        if (rv_a || rv_b) begin
            if (q_exp.size() == 0) begin
                checks++; errors++;
                $display("FAIL R12: actual response 0x%0h expected none", rv_a ? rdata_a : rdata_b);
            end else begin
                s = q_sel.pop_front(); e = q_exp.pop_front(); t = q_tag.pop_front();
                check({t, " response side"}, {63'd0, s ? rv_b : rv_a}, 64'd1);
                check(t, {32'd0, s ? rdata_b : rdata_a}, {32'd0, e});
            end
        end
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin : watchdog
        #(CLK_P * 50000);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 reset state, R4 decode of reset fields, R7 lengths
        check("R3 enable cleared at reset", {63'd0, en_a}, 64'd0);
        check("R3 address at reset", addr_a, 64'd0);
        check("R3 mask at reset", {32'd0, mask_a}, 64'd0);
        check("R4 count field 0", {58'd0, cnt_a}, 64'd1);
        check("R4 count field 6", {58'd0, cnt_b}, 64'd0);
        check("R7 length wide+mask", {56'd0, len_a}, 64'h18);
        check("R7 length narrow", {56'd0, len_b}, 64'h0A);
        check("R12 idle rvalid", {62'd0, rv_a, rv_b}, 64'd0);

        // R1 header reads
        rd(0, 8'h00, 2'd2, 32'h0186A505, "R1 word 0 wide");
        rd(0, 8'h00, 2'd0, 32'h00000005, "R1 byte 0");
        rd(0, 8'h01, 2'd0, 32'h000000A5, "R1 byte 1");
        rd(0, 8'h00, 2'd1, 32'h0000A505, "R1 half 0");
        rd(0, 8'h02, 2'd1, 32'h00000186, "R3 control after reset");
        rd(1, 8'h00, 2'd2, 32'h006A4005, "R1 word 0 narrow");

        // R2 writable subset of control
        wr(0, 8'h00, 2'd2, 32'hFFFF0000);
        check("R2 enable via word 0", {63'd0, en_a}, 64'd1);
        check("R4 count field 7", {58'd0, cnt_a}, 64'd0);
        rd(0, 8'h02, 2'd1, 32'h000001F7, "R2 read-only bits kept");
        wr(0, 8'h02, 2'd1, 32'h00000030);
        check("R2 enable cleared via half", {63'd0, en_a}, 64'd0);
        check("R4 count field 3", {58'd0, cnt_a}, 64'd8);
        wr(0, 8'h02, 2'd1, 32'h00000051);
        check("R4 count field 5", {58'd0, cnt_a}, 64'd32);
        check("R2 enable set via half", {63'd0, en_a}, 64'd1);

        // R5 and R6 address and data on the wide layout
        wr(0, 8'h04, 2'd2, 32'h1234567F);
        rd(0, 8'h04, 2'd2, 32'h1234567C, "R5 low address aligned");
        wr(0, 8'h08, 2'd2, 32'hDEADBEEF);
        check("R6 wide address output", addr_a, 64'hDEADBEEF_1234567C);
        rd(0, 8'h08, 2'd2, 32'hDEADBEEF, "R6 upper address at 0x8");
        wr(0, 8'h0C, 2'd1, 32'h0000A5A5);
        rd(0, 8'h0C, 2'd1, 32'h0000A5A5, "R6 data half at 0xC");
        wr(0, 8'h0C, 2'd2, 32'hA5A5A5A4);
        rd(0, 8'h0C, 2'd2, 32'h0000A5A4, "R6 data word at 0xC");
        check("R6 data output", {48'd0, data_a}, 64'hA5A4);

        // R9 partial mask writes
        wr(0, 8'h10, 2'd2, 32'h00000000);
        wr(0, 8'h11, 2'd0, 32'h0000003C);
        wr(0, 8'h12, 2'd1, 32'h0000BEEF);
        wr(0, 8'h10, 2'd0, 32'h0000000F);
        rd(0, 8'h10, 2'd2, 32'hBEEF3C0F, "R9 mask merged");
        rd(0, 8'h13, 2'd0, 32'h000000BE, "R9 mask byte 3");
        rd(0, 8'h12, 2'd1, 32'h0000BEEF, "R9 mask upper half");
        check("R9 mask output", {32'd0, mask_a}, 64'hBEEF3C0F);

        // R8 pending window
        wr(0, 8'h10, 2'd2, 32'h000000F0);
        pend_a = 8'h3C;
        rd(0, 8'h14, 2'd2, 32'h00000030, "R8 pending word masked and set");
        rd(0, 8'h14, 2'd0, 32'h00000030, "R8 pending byte");
        rd(0, 8'h14, 2'd1, 32'h00000030, "R8 pending half");
        pend_a = 8'hFF;
        wr(0, 8'h10, 2'd2, 32'hFFFFFF0F);
        rd(0, 8'h14, 2'd2, 32'h0000000F, "R8 unmasked and absent vectors read 0");
        wr(0, 8'h02, 2'd1, 32'h00000050);
        rd(0, 8'h14, 2'd2, 32'h00000000, "R8 pending while disabled");

        // R11 unmapped accesses on the wide instance
        rd(0, 8'h20, 2'd2, 32'h00000000, "R11 unmapped word read");
        rd(0, 8'h02, 2'd0, 32'h00000000, "R11 byte read at 2");
        wr(0, 8'h20, 2'd2, 32'hFFFFFFFF);
        wr(0, 8'h02, 2'd0, 32'h000000FF);
        check("R11 enable untouched", {63'd0, en_a}, 64'd0);
        check("R11 count untouched", {58'd0, cnt_a}, 64'd32);
        check("R11 address untouched", addr_a, 64'hDEADBEEF_1234567C);
        check("R11 data untouched", {48'd0, data_a}, 64'hA5A4);
        check("R11 mask untouched", {32'd0, mask_a}, 64'hFFFFFF0F);
        rd(0, 8'h02, 2'd1, 32'h000001D6, "R11 control untouched");

        // Narrow instance without per-vector masking
        wr(1, 8'h08, 2'd2, 32'h12349876);
        rd(1, 8'h08, 2'd2, 32'h00009876, "R6 narrow data word at 0x8");
        rd(1, 8'h08, 2'd1, 32'h00009876, "R6 narrow data half");
        check("R6 narrow data output", {48'd0, data_b}, 64'h9876);
        wr(1, 8'h04, 2'd2, 32'hFFFFFFFF);
        check("R5 narrow address aligned, no upper", addr_b, 64'h00000000_FFFFFFFC);
        wr(1, 8'h0C, 2'd2, 32'hFFFFFFFF);
        check("R10 mask absent", {32'd0, mask_b}, 64'd0);
        rd(1, 8'h0C, 2'd2, 32'h00000000, "R11 narrow 0xC unmapped");
        wr(1, 8'h02, 2'd1, 32'h00000001);
        check("R2 narrow enable", {63'd0, en_b}, 64'd1);
        check("R4 narrow count field 0", {58'd0, cnt_b}, 64'd1);
        pend_b = 32'hFFFFFFFF;
        rd(1, 8'h10, 2'd2, 32'h00000000, "R8 no pending window without masking");
        rd(1, 8'h00, 2'd2, 32'h000B4005, "R1 narrow word 0 after write");

        repeat (3) @(negedge clk);
        check("R12 all responses seen", {32'd0, 32'(q_exp.size())}, 64'd0);
        summary();
        $finish;
    end
endmodule